// File: doc/BRIEF.md
# HDLC Receive Buffer with Message-Bounded Read Accounting

This block sits between an HDLC deframer and a host read port and holds up to 128 received bytes. The deframer pushes one byte per cycle. The byte that closes a frame carries an end marker and a 3-bit packet status. The host reads bytes one at a time from the head of the buffer.

The block does not report a raw fill level to the host. It reports how many bytes can be read without crossing the end of the message at the head. It also says what kind of chunk those bytes form: the opening part of a packet, a middle part, the closing part, or a whole packet.

After the host reads the closing byte of a message, a status field gives the outcome of that packet. A programmable fill threshold drives a status bit and a maskable interrupt. If the deframer writes while the buffer is full, the packet that is still open is closed with an overrun status, and the rest of that packet is thrown away.

Top module: `hdlc_rx_pkt_fifo`

## Requirements
- R1: After reset the buffer is empty: `availCount` = 0, `pktStatus` = 0, `msgCont` = 0, `chunkKind` = 1, and `hwmStatus` and `irq` are low.
- R2: Bytes leave in the order they were written, and `rdData` always shows the head byte. A read strobe on an empty buffer changes nothing, including `pktStatus`.
- R3: The buffer accepts 128 bytes with no read in between, and all of them can later be read back.
- R4: If the end byte of the head message is in the buffer, `availCount` is the number of bytes from the head through that end byte. Otherwise it is the number of buffered bytes. Any value above 127 is shown as 127.
- R5: `chunkKind` bit 0 is set while no byte of the head message has been read yet. Bit 1 is set while the end byte of the head message is in the buffer. So 1 = opening part, 0 = middle part, 2 = closing part, 3 = whole packet.
- R6: `msgCont` is low when the head byte is the last byte of its message or when the buffer is empty. It is high otherwise.
- R7: Each accepted read updates `pktStatus`. It takes the stored status of the byte read if that byte ended a message, and 0 otherwise. Status codes: 0 in progress, 1 good, 2 CRC error, 3 abort, 4 overrun, 5 invalid.
- R8: A write that arrives while 128 bytes are stored, and while the open message has a stored byte, does three things. The newest stored byte becomes the message end with status 4. The written byte is dropped. Every later byte of that packet, up to and including its end byte, is also dropped, even if space frees up in the meantime.
- R9: A packet whose first byte arrives while the buffer is full is dropped entirely, up to and including its end byte. The stored contents do not change.
- R10: `hwmStatus` is high while the fill is at least 16 × (`hwmLevel` + 1). `irq` is `hwmStatus` gated by `hwmIrqEn`.
- R11: A write and a read in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Deframer byte strobe |
| wrData | input | 8 | Received byte |
| wrEof | input | 1 | Byte closes its frame |
| wrStatus | input | 3 | Packet status, valid with wrEof |
| rdEn | input | 1 | Host pops the head byte |
| rdData | output | 8 | Head byte |
| availCount | output | 7 | Bytes readable up to the end of the head message |
| chunkKind | output | 2 | Position of the readable chunk within its packet |
| msgCont | output | 1 | Low when the head byte ends a message |
| pktStatus | output | 3 | Outcome of the last message read |
| hwmLevel | input | 3 | Fill threshold select |
| hwmIrqEn | input | 1 | Interrupt mask enable |
| hwmStatus | output | 1 | Fill at or above threshold |
| irq | output | 1 | Masked threshold interrupt |

## Verification
The bench fills the buffer with one message longer than 127 bytes. A design that does not clip the count would wrap `availCount` to zero. The bench then causes an overrun and frees a byte mid-discard. A design that stops discarding as soon as space appears would store fragments of the dropped packet, and the bench sees them in the read order. The bench also starts a packet while the buffer is full of complete packets and checks that none of that packet's bytes show up. Finally, it pops on an empty buffer, because a careless design would clear `pktStatus` there.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  typedef enum logic [2:0] {
    PS_BUSY    = 3'd0,
    PS_GOOD    = 3'd1,
    PS_CRC     = 3'd2,
    PS_ABORT   = 3'd3,
    PS_OVERRUN = 3'd4,
    PS_INVALID = 3'd5
  } pktStat_e;

  typedef enum logic [1:0] {
    CK_MIDDLE = 2'd0,
    CK_OPEN   = 2'd1,
    CK_CLOSE  = 2'd2,
    CK_WHOLE  = 2'd3
  } chunk_e;

  // one buffered byte with its frame tag
  typedef struct packed {
    logic [7:0] data;
    logic       eof;
    logic [2:0] stat;
  } entry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic store;      // write incoming byte at tail
    logic closeTail;  // retag newest byte as overrun end
    logic recordLen;  // push a message length
    logic pop;        // advance head
  } strobe_t;

endpackage

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
  import hdlc_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrValid,
  input  logic    wrEof,
  input  logic    rdEn,
  input  logic    full,
  input  logic    empty,
  input  logic    tailOpen,
  output strobe_t strb
);

  logic discard, discardNext;

  always_comb begin
    strb        = '0;
    discardNext = discard;
    if (wrValid) begin
      if (discard) begin
        if (wrEof) discardNext = 1'b0;
      end else if (!full) begin
        strb.store     = 1'b1;
        strb.recordLen = wrEof;
      end else begin
        strb.closeTail = tailOpen;
        strb.recordLen = tailOpen;
        discardNext    = !wrEof;
      end
    end
    strb.pop = rdEn && !empty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) discard <= 1'b0;
    else       discard <= discardNext;
  end

  // R9 / R8: while dropping the rest of a packet nothing is stored
  p_discard_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    discard |-> !strb.store);

  // R8: an overrun close only happens on a write into a full buffer
  p_close_needs_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.closeTail |-> (full && wrValid));

endmodule

// File: rtl/hdlc_rx_dpath.sv
module hdlc_rx_dpath
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH   = 128,
  parameter int AVAIL_W = 7,
  parameter int PTR_W   = $clog2(DEPTH),
  parameter int CNT_W   = PTR_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [7:0]         wrData,
  input  logic               wrEof,
  input  logic [2:0]         wrStatus,
  output logic [7:0]         headData,
  output logic [AVAIL_W-1:0] availCount,
  output logic [1:0]         chunkKind,
  output logic               msgCont,
  output logic [2:0]         pktStatus,
  output logic [CNT_W-1:0]   fill,
  output logic               full,
  output logic               empty,
  output logic               tailOpen,
  output logic               headEof
);

  localparam logic [CNT_W-1:0] AV_MAX = CNT_W'((1 << AVAIL_W) - 1);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

  entry_t           mem    [DEPTH];
  logic [CNT_W-1:0] lenMem [DEPTH];

  logic [PTR_W-1:0] wrPtr, rdPtr, lenWr, lenRd, lastPtr;
  logic [CNT_W-1:0] lenCnt, curLen, popOff, rawAvail;
  logic             headStarted, lenPop;
  entry_t           headEntry;

  assign lastPtr   = wrPtr - PTR_W'(1);
  assign headEntry = mem[rdPtr];
  assign full      = (fill == FULL_C);
  assign empty     = (fill == '0);
  assign headEof   = !empty && headEntry.eof;
  assign lenPop    = strb.pop && headEof;

  // storage arrays, no reset
  always_ff @(posedge clk) begin
    if (strb.store) mem[wrPtr] <= '{data: wrData, eof: wrEof, stat: wrStatus};
    if (strb.closeTail) begin
      mem[lastPtr].eof  <= 1'b1;
      mem[lastPtr].stat <= PS_OVERRUN;
    end
    if (strb.recordLen) lenMem[lenWr] <= strb.store ? curLen + CNT_W'(1) : curLen;
  end

  // byte pointers and fill
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (strb.store) wrPtr <= wrPtr + PTR_W'(1);
      if (strb.pop)   rdPtr <= rdPtr + PTR_W'(1);
      unique case ({strb.store, strb.pop})
        2'b10:   fill <= fill + CNT_W'(1);
        2'b01:   fill <= fill - CNT_W'(1);
        default: fill <= fill;
      endcase
    end
  end

  // message length queue
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenWr  <= '0;
      lenRd  <= '0;
      lenCnt <= '0;
    end else begin
      if (strb.recordLen) lenWr <= lenWr + PTR_W'(1);
      if (lenPop)         lenRd <= lenRd + PTR_W'(1);
      unique case ({strb.recordLen, lenPop})
        2'b10:   lenCnt <= lenCnt + CNT_W'(1);
        2'b01:   lenCnt <= lenCnt - CNT_W'(1);
        default: lenCnt <= lenCnt;
      endcase
    end
  end

  // tail side message tracking (lengths kept modulo 2**CNT_W)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLen   <= '0;
      tailOpen <= 1'b0;
    end else if (strb.store) begin
      curLen   <= wrEof ? '0 : curLen + CNT_W'(1);
      tailOpen <= !wrEof;
    end else if (strb.closeTail) begin
      curLen   <= '0;
      tailOpen <= 1'b0;
    end
  end

  // head side message tracking and outcome
  always_ff @(posedge clk) begin
    if (!rstN) begin
      popOff      <= '0;
      headStarted <= 1'b0;
      pktStatus   <= PS_BUSY;
    end else if (strb.pop) begin
      popOff      <= headEof ? '0 : popOff + CNT_W'(1);
      headStarted <= !headEof;
      pktStatus   <= headEof ? headEntry.stat : PS_BUSY;
    end
  end

  always_comb begin
    rawAvail   = (lenCnt == '0) ? fill : lenMem[lenRd] - popOff;
    availCount = (rawAvail > AV_MAX) ? AV_MAX[AVAIL_W-1:0] : rawAvail[AVAIL_W-1:0];
  end

  assign chunkKind = {lenCnt != '0, !headStarted};
  assign msgCont   = !empty && !headEntry.eof;
  assign headData  = headEntry.data;

  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    fill <= FULL_C);

  p_no_store_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.store |-> !full);

  p_ends_le_fill_r4: assert property (@(posedge clk) disable iff (!rstN)
    lenCnt <= fill);

  p_avail_le_fill_r4: assert property (@(posedge clk) disable iff (!rstN)
    CNT_W'(availCount) <= fill);

  p_status_on_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && headEof) |=> (pktStatus == $past(headEntry.stat)));

  p_status_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.pop |=> $stable(pktStatus));

endmodule

// File: rtl/hdlc_rx_hwm.sv
module hdlc_rx_hwm #(
  parameter int DEPTH = 128,
  parameter int LVL_W = 3,
  parameter int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] fill,
  input  logic [LVL_W-1:0] level,
  input  logic             irqEn,
  output logic             hwmStatus,
  output logic             irq
);

  localparam int STEP = DEPTH >> LVL_W;

  logic [CNT_W:0] thr;

  always_comb begin
    thr       = (CNT_W+1)'((int'(level) + 1) * STEP);
    hwmStatus = ({1'b0, fill} >= thr);
    irq       = hwmStatus && irqEn;
  end

  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (irqEn && fill != '0));

endmodule

// File: rtl/hdlc_rx_pkt_fifo.sv
module hdlc_rx_pkt_fifo
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH   = 128,
  parameter int AVAIL_W = 7,
  parameter int LVL_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrValid,
  input  logic [7:0]         wrData,
  input  logic               wrEof,
  input  logic [2:0]         wrStatus,
  input  logic               rdEn,
  output logic [7:0]         rdData,
  output logic [AVAIL_W-1:0] availCount,
  output logic [1:0]         chunkKind,
  output logic               msgCont,
  output logic [2:0]         pktStatus,
  input  logic [LVL_W-1:0]   hwmLevel,
  input  logic               hwmIrqEn,
  output logic               hwmStatus,
  output logic               irq
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  strobe_t          strb;
  logic [CNT_W-1:0] fill;
  logic             full, empty, tailOpen, headEof;

  hdlc_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrEof(wrEof), .rdEn(rdEn),
    .full(full), .empty(empty), .tailOpen(tailOpen), .strb(strb)
  );

  hdlc_rx_dpath #(.DEPTH(DEPTH), .AVAIL_W(AVAIL_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .wrEof(wrEof),
    .wrStatus(wrStatus), .headData(rdData), .availCount(availCount),
    .chunkKind(chunkKind), .msgCont(msgCont), .pktStatus(pktStatus),
    .fill(fill), .full(full), .empty(empty), .tailOpen(tailOpen), .headEof(headEof)
  );

  hdlc_rx_hwm #(.DEPTH(DEPTH), .LVL_W(LVL_W), .CNT_W(CNT_W)) u_hwm (
    .clk(clk), .rstN(rstN), .fill(fill), .level(hwmLevel), .irqEn(hwmIrqEn),
    .hwmStatus(hwmStatus), .irq(irq)
  );

  // R6: a head byte that ends a message never reports continuation
  p_cont_vs_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    headEof |-> !msgCont);

endmodule

// File: tb/hdlc_rx_pkt_fifo_bench.sv
module hdlc_rx_pkt_fifo_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrValid = 1'b0, wrEof = 1'b0, rdEn = 1'b0, hwmIrqEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [2:0] wrStatus = '0, hwmLevel = '0;
  logic [7:0] rdData;
  logic [6:0] availCount;
  logic [1:0] chunkKind;
  logic       msgCont, hwmStatus, irq;
  logic [2:0] pktStatus;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_pkt_fifo u_hdlc_rx_pkt_fifo (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData), .wrEof(wrEof),
    .wrStatus(wrStatus), .rdEn(rdEn), .rdData(rdData), .availCount(availCount),
    .chunkKind(chunkKind), .msgCont(msgCont), .pktStatus(pktStatus),
    .hwmLevel(hwmLevel), .hwmIrqEn(hwmIrqEn), .hwmStatus(hwmStatus), .irq(irq)
  );

  typedef struct packed {
    logic       wv;
    logic [7:0] wd;
    logic       we;
    logic [2:0] ws;
    logic       rd;
    logic [6:0] av;
    logic [1:0] ck;
    logic       mc;
    logic [2:0] ps;
    logic       hd;
    logic [7:0] head;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{1'b1, 8'h11, 1'b0, 3'd0, 1'b0, 7'd1, 2'd1, 1'b1, 3'd0, 1'b1, 8'h11},
    '{1'b1, 8'h22, 1'b0, 3'd0, 1'b0, 7'd2, 2'd1, 1'b1, 3'd0, 1'b1, 8'h11},
    '{1'b1, 8'h33, 1'b1, 3'd1, 1'b0, 7'd3, 2'd3, 1'b1, 3'd0, 1'b1, 8'h11},
    '{1'b1, 8'h44, 1'b1, 3'd2, 1'b0, 7'd3, 2'd3, 1'b1, 3'd0, 1'b1, 8'h11},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b1, 7'd2, 2'd2, 1'b1, 3'd0, 1'b1, 8'h22},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b1, 7'd1, 2'd2, 1'b0, 3'd0, 1'b1, 8'h33},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b1, 7'd1, 2'd3, 1'b0, 3'd1, 1'b1, 8'h44},
    '{1'b1, 8'h55, 1'b0, 3'd0, 1'b1, 7'd1, 2'd1, 1'b1, 3'd2, 1'b1, 8'h55}, // R11
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b1, 7'd0, 2'd0, 1'b0, 3'd0, 1'b0, 8'h00},
    '{1'b1, 8'h66, 1'b0, 3'd0, 1'b0, 7'd1, 2'd0, 1'b1, 3'd0, 1'b1, 8'h66},
    '{1'b1, 8'h77, 1'b1, 3'd3, 1'b0, 7'd2, 2'd2, 1'b1, 3'd0, 1'b1, 8'h66},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b1, 7'd1, 2'd2, 1'b0, 3'd0, 1'b1, 8'h77},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b1, 7'd0, 2'd1, 1'b0, 3'd3, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b1, 7'd0, 2'd1, 1'b0, 3'd3, 1'b0, 8'h00}, // R2 empty pop
    '{1'b1, 8'h88, 1'b1, 3'd5, 1'b0, 7'd1, 2'd3, 1'b0, 3'd3, 1'b1, 8'h88},
    '{1'b0, 8'h00, 1'b0, 3'd0, 1'b1, 7'd0, 2'd1, 1'b0, 3'd5, 1'b0, 8'h00}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic wv, input logic [7:0] wd, input logic we,
                     input logic [2:0] ws, input logic rd);
    wrValid = wv; wrData = wd; wrEof = we; wrStatus = ws; rdEn = rd;
    @(negedge clk);
    wrValid = 1'b0; wrEof = 1'b0; rdEn = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish();
  end

  initial begin
    int errs;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 avail", availCount, 0);
    chk("R1 status", pktStatus, 0);
    chk("R1 cont", msgCont, 0);
    chk("R1 kind", chunkKind, 1);
    chk("R1 hwm", hwmStatus, 0);
    chk("R1 irq", irq, 0);

    // table walk: R2 R4 R5 R6 R7 R11
    foreach (VECS[i]) begin
      cyc(VECS[i].wv, VECS[i].wd, VECS[i].we, VECS[i].ws, VECS[i].rd);
      chk($sformatf("R4 avail row %0d", i), availCount, VECS[i].av);
      chk($sformatf("R5 kind row %0d", i), chunkKind, VECS[i].ck);
      chk($sformatf("R6 cont row %0d", i), msgCont, VECS[i].mc);
      chk($sformatf("R7 status row %0d", i), pktStatus, VECS[i].ps);
      if (VECS[i].hd) chk($sformatf("R2 head row %0d", i), rdData, VECS[i].head);
    end

    // R3 capacity and R10 threshold with one long open message
    hwmLevel = 3'd0;
    hwmIrqEn = 1'b1;
    for (int i = 0; i < 128; i++) begin
      cyc(1'b1, 8'(i), 1'b0, 3'd0, 1'b0);
      if (i == 14) chk("R10 below level0", hwmStatus, 0);
      if (i == 15) begin
        chk("R10 at level0", hwmStatus, 1);
        chk("R10 irq enabled", irq, 1);
      end
    end
    chk("R4 clip 128 to 127", availCount, 127);
    chk("R5 open part", chunkKind, 1);
    hwmLevel = 3'd6;
    #1 chk("R10 level6 full", hwmStatus, 1);
    hwmLevel = 3'd7;
    hwmIrqEn = 1'b0;
    #1 chk("R10 level7 full", hwmStatus, 1);
    chk("R10 irq masked", irq, 0);

    // R8 overrun close and discard across freed space
    cyc(1'b1, 8'hEE, 1'b0, 3'd0, 1'b0);
    chk("R8 closed whole", chunkKind, 3);
    chk("R8 avail clipped", availCount, 127);
    cyc(1'b0, 8'h00, 1'b0, 3'd0, 1'b1);
    chk("R8 close part", chunkKind, 2);
    cyc(1'b1, 8'hEF, 1'b0, 3'd0, 1'b0);
    cyc(1'b1, 8'hF0, 1'b1, 3'd1, 1'b0);
    cyc(1'b1, 8'hF1, 1'b1, 3'd1, 1'b0);
    chk("R8 head after pop", rdData, 1);
    chk("R8 avail", availCount, 127);
    errs = 0;
    for (int i = 1; i < 127; i++) begin
      if (rdData != 8'(i)) errs++;
      cyc(1'b0, 8'h00, 1'b0, 3'd0, 1'b1);
    end
    chk("R3 read order", errs, 0);
    chk("R8 last kept byte", rdData, 127);
    chk("R8 last avail", availCount, 1);
    chk("R6 last byte", msgCont, 0);
    cyc(1'b0, 8'h00, 1'b0, 3'd0, 1'b1);
    chk("R8 overrun status", pktStatus, 4);
    chk("R8 next packet head", rdData, 8'hF1);
    chk("R8 next kind", chunkKind, 3);
    cyc(1'b0, 8'h00, 1'b0, 3'd0, 1'b1);
    chk("R8 dropped bytes absent", availCount, 0);
    chk("R7 good status", pktStatus, 1);

    // R9 packet begun while full of complete packets
    for (int k = 0; k < 64; k++) begin
      cyc(1'b1, 8'(2*k), 1'b0, 3'd0, 1'b0);
      cyc(1'b1, 8'(2*k+1), 1'b1, 3'd1, 1'b0);
    end
    chk("R10 full level7", hwmStatus, 1);
    cyc(1'b1, 8'hA0, 1'b0, 3'd0, 1'b0);
    cyc(1'b1, 8'hA1, 1'b1, 3'd2, 1'b0);
    chk("R9 avail", availCount, 2);
    chk("R9 kind", chunkKind, 3);
    cyc(1'b0, 8'h00, 1'b0, 3'd0, 1'b1);
    cyc(1'b0, 8'h00, 1'b0, 3'd0, 1'b1);
    chk("R9 first packet status", pktStatus, 1);
    cyc(1'b1, 8'hB0, 1'b1, 3'd1, 1'b0);
    errs = 0;
    for (int i = 2; i < 128; i++) begin
      if (rdData != 8'(i)) errs++;
      cyc(1'b0, 8'h00, 1'b0, 3'd0, 1'b1);
    end
    chk("R9 stored content", errs, 0);
    chk("R9 new packet kept", rdData, 8'hB0);
    chk("R9 new avail", availCount, 1);
    cyc(1'b0, 8'h00, 1'b0, 3'd0, 1'b1);
    chk("R9 drained", availCount, 0);
    chk("R10 empty", hwmStatus, 0);

    // R1 reset with data present
    hwmLevel = 3'd0;
    cyc(1'b1, 8'h5A, 1'b1, 3'd2, 1'b0);
    cyc(1'b0, 8'h00, 1'b0, 3'd0, 1'b1);
    cyc(1'b1, 8'h5B, 1'b0, 3'd0, 1'b0);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R1 reset avail", availCount, 0);
    chk("R1 reset status", pktStatus, 0);
    chk("R1 reset cont", msgCont, 0);
    finish();
  end

endmodule